// File: doc/BRIEF.md
# Instruction Cache Entry Parity Checker

This block checks one instruction-cache way entry for parity damage. A caller offers the entry's 64-bit low tag word together with the valid flag and its parity copy from the high tag word. The caller also says whether the line's data follows. When it does, the block takes one data beat per handshake. Each beat carries two 32-bit instructions and a 17-bit side word, which holds the predecode byte, the predecode parity bit and two 4-bit instruction parity codes.

Once the tag and every beat have been checked, the block raises `done` for one cycle. At that point it presents a tag-parity flag, a data-parity flag and a mask of the beats that failed. All three results hold until the next tag is accepted. Tag checks are combinational on the offered word and are captured at acceptance. Beat checks are captured as each beat is accepted.

Top module: `icache_parity_chk`

## Requirements
- R1: When the valid flag is 1, `tag_err` is set if tag-low bit 10 differs from the XOR of tag-low bits 23:0 with bits 11 and 10 excluded.
- R2: When the valid flag is 1, `tag_err` is set if tag-low bit 11 differs from the XOR of tag-low bits 63:24. When the valid flag is 0, neither range check has any effect.
- R3: `tag_err` is set whenever the valid flag and its parity copy differ, whatever the valid flag's value.
- R4: A beat fails if side-word bit 16 differs from the XOR of side-word bits 15:8, the predecode byte.
- R5: A beat fails if side bits 7:4 differ from the byte-parity code of instruction A, or if side bits 3:0 differ from the code of instruction B. In each code, bit 3 is the XOR of instruction bits 31:24, bit 2 of bits 23:16, bit 1 of bits 15:8 and bit 0 of bits 7:0.
- R6: When data follows, exactly NUM_BEATS beats (default 4) are taken. Bit i of `fail_mask` is 1 when the i-th accepted beat failed. `data_err` is 1 when any bit of `fail_mask` is set.
- R7: The result flags and the mask stay set across beats and hold after `done`. All three clear when a new tag is accepted, so an entry without data reports `data_err` 0 and `fail_mask` 0.
- R8: `tag_ready` is 1 only while the block is idle, and `beat_ready` is 1 only while beats are awaited. A beat offered outside that window, or a cycle in which `beat_valid` is 0, changes nothing. `done` is a one-cycle pulse in the cycle after the last beat is accepted, or after the tag when no data follows.
- R9: After reset, `tag_ready` is 1, `beat_ready` and `done` are 0, and all flags and the mask are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tag_valid | input | 1 | Tag offer |
| tag_ready | output | 1 | Tag accepted when both are high |
| tag_lo | input | 64 | Low tag word with parity bits 10 and 11 |
| entry_vld | input | 1 | Valid flag from the high tag word |
| entry_vld_par | input | 1 | Parity copy of the valid flag |
| tag_has_data | input | 1 | Data beats follow this tag |
| beat_valid | input | 1 | Data beat offer |
| beat_ready | output | 1 | Beat accepted when both are high |
| beat_insn_a | input | 32 | First instruction of the beat |
| beat_insn_b | input | 32 | Second instruction of the beat |
| beat_side | input | 17 | Predecode parity, predecode byte, parity codes A and B |
| done | output | 1 | One-cycle completion pulse |
| tag_err | output | 1 | Tag parity failure |
| data_err | output | 1 | Any beat failed |
| fail_mask | output | NUM_BEATS | Per-beat failure bits, bit 0 first beat |

## Verification
The bench builds the block with the default of four beats per line. With that size, every mask bit position and every gap pattern between beats can be reached within a few hundred entries. Pseudo-random tag words with randomly set parity bits cover both tag ranges, both values of the valid flag and mismatched valid copies. Beats corrupted in a randomly chosen bit reach the predecode check and both instruction codes in every byte lane. Directed entries isolate the gating of the range checks by the valid flag and the clearing of stale results by a following entry that has no data.

// File: rtl/icp_pkg.sv
package icp_pkg;

    localparam int TAG_LO_W   = 64;
    localparam int INSN_W     = 32;
    localparam int PD_W       = 8;
    localparam int CODE_W     = 4;
    localparam int SIDE_W     = PD_W + 1 + 2 * CODE_W;
    localparam int LO_PAR_BIT = 10;
    localparam int HI_PAR_BIT = 11;
    localparam int LO_RNG_TOP = 23;
    localparam int HI_RNG_BOT = 24;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BEATS = 2'd1,
        ST_REPORT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic lo_rng_err;
        logic hi_rng_err;
        logic vflag_err;
    } tag_res_t;

    typedef struct packed {
        logic pd_par;
        logic [PD_W-1:0] pd_byte;
        logic [CODE_W-1:0] code_a;
        logic [CODE_W-1:0] code_b;
    } side_t;

    typedef struct packed {
        logic pd_err;
        logic a_err;
        logic b_err;
    } beat_res_t;

    // Per-byte even parity, most significant byte lands in the top bit.
    function automatic logic [CODE_W-1:0] insn_code(input logic [INSN_W-1:0] w);
        logic [CODE_W-1:0] c;
        for (int k = 0; k < CODE_W; k++) begin
            c[k] = ^w[k*8 +: 8];
        end
        return c;
    endfunction

    function automatic logic lo_range_par(input logic [TAG_LO_W-1:0] lo);
        logic [LO_RNG_TOP:0] r;
        r = lo[LO_RNG_TOP:0];
        r[HI_PAR_BIT] = 1'b0;
        r[LO_PAR_BIT] = 1'b0;
        return ^r;
    endfunction

endpackage

// File: rtl/icp_tag_check.sv
module icp_tag_check
    import icp_pkg::*;
(
    input  logic [TAG_LO_W-1:0] tag_lo,
    input  logic                entry_vld,
    input  logic                entry_vld_par,
    output tag_res_t            res,
    output logic                any_err
);
    always_comb begin
        res.vflag_err  = entry_vld ^ entry_vld_par;
        res.lo_rng_err = entry_vld & (tag_lo[LO_PAR_BIT] ^ lo_range_par(tag_lo));
        res.hi_rng_err = entry_vld & (tag_lo[HI_PAR_BIT] ^ (^tag_lo[TAG_LO_W-1:HI_RNG_BOT]));
        any_err        = |res;
    end
endmodule

// File: rtl/icp_beat_check.sv
module icp_beat_check
    import icp_pkg::*;
(
    input  logic [INSN_W-1:0] insn_a,
    input  logic [INSN_W-1:0] insn_b,
    input  logic [SIDE_W-1:0] side_raw,
    output beat_res_t         res,
    output logic              any_err
);
    side_t side;
    logic [1:0][INSN_W-1:0] insns;
    logic [1:0][CODE_W-1:0] codes;
    logic [1:0]             code_bad;

    assign side  = side_t'(side_raw);
    assign insns = {insn_a, insn_b};
    assign codes = {side.code_a, side.code_b};

    for (genvar g = 0; g < 2; g++) begin : g_insn
        assign code_bad[g] = |(codes[g] ^ insn_code(insns[g]));
    end

    always_comb begin
        res.pd_err = side.pd_par ^ (^side.pd_byte);
        res.a_err  = code_bad[1];
        res.b_err  = code_bad[0];
        any_err    = |res;
    end
endmodule

// File: rtl/icp_seq.sv
module icp_seq
    import icp_pkg::*;
#(
    parameter int NUM_BEATS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tag_valid,
    output logic                 tag_ready,
    input  logic                 tag_has_data,
    input  logic                 tag_bad,
    input  logic                 beat_valid,
    output logic                 beat_ready,
    input  logic                 beat_bad,
    output logic                 done,
    output logic                 tag_err,
    output logic                 data_err,
    output logic [NUM_BEATS-1:0] fail_mask
);
    localparam int CNT_W = (NUM_BEATS > 1) ? $clog2(NUM_BEATS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_BEATS - 1);

    seq_state_e          state;
    logic [CNT_W-1:0]    cnt;
    logic [NUM_BEATS-1:0] beat_sel;

    assign tag_ready  = (state == ST_IDLE);
    assign beat_ready = (state == ST_BEATS);
    assign done       = (state == ST_REPORT);

    always_comb begin
        for (int i = 0; i < NUM_BEATS; i++) begin
            beat_sel[i] = (cnt == CNT_W'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            tag_err   <= 1'b0;
            data_err  <= 1'b0;
            fail_mask <= '0;
        end else begin
            case (state)
                ST_IDLE: if (tag_valid) begin
                    tag_err   <= tag_bad;
                    data_err  <= 1'b0;
                    fail_mask <= '0;
                    cnt       <= '0;
                    state     <= tag_has_data ? ST_BEATS : ST_REPORT;
                end
                ST_BEATS: if (beat_valid) begin
                    if (beat_bad) begin
                        fail_mask <= fail_mask | beat_sel;
                        data_err  <= 1'b1;
                    end
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) state <= ST_REPORT;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    ready_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(tag_ready && beat_ready));

    // R8
    nodata_done_chk: assert property (@(posedge clk) disable iff (rst)
        (tag_valid && tag_ready && !tag_has_data) |=> done);

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (data_err && !(tag_valid && tag_ready)) |=> data_err);

    // R6
    mask_flag_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (data_err == (fail_mask != '0)));

    // R7
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !beat_ready) |=> $stable(fail_mask));
endmodule

// File: rtl/icache_parity_chk.sv
module icache_parity_chk
    import icp_pkg::*;
#(
    parameter int NUM_BEATS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tag_valid,
    output logic                 tag_ready,
    input  logic [63:0]          tag_lo,
    input  logic                 entry_vld,
    input  logic                 entry_vld_par,
    input  logic                 tag_has_data,
    input  logic                 beat_valid,
    output logic                 beat_ready,
    input  logic [31:0]          beat_insn_a,
    input  logic [31:0]          beat_insn_b,
    input  logic [16:0]          beat_side,
    output logic                 done,
    output logic                 tag_err,
    output logic                 data_err,
    output logic [NUM_BEATS-1:0] fail_mask
);
    tag_res_t  tag_res;
    beat_res_t beat_res;
    logic      tag_bad;
    logic      beat_bad;

    icp_tag_check u_tag (
        .tag_lo        (tag_lo),
        .entry_vld     (entry_vld),
        .entry_vld_par (entry_vld_par),
        .res           (tag_res),
        .any_err       (tag_bad)
    );

    icp_beat_check u_beat (
        .insn_a   (beat_insn_a),
        .insn_b   (beat_insn_b),
        .side_raw (beat_side),
        .res      (beat_res),
        .any_err  (beat_bad)
    );

    icp_seq #(.NUM_BEATS(NUM_BEATS)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .tag_valid    (tag_valid),
        .tag_ready    (tag_ready),
        .tag_has_data (tag_has_data),
        .tag_bad      (tag_bad),
        .beat_valid   (beat_valid),
        .beat_ready   (beat_ready),
        .beat_bad     (beat_bad),
        .done         (done),
        .tag_err      (tag_err),
        .data_err     (data_err),
        .fail_mask    (fail_mask)
    );

    // R3
    vflag_chk: assert property (@(posedge clk) disable iff (rst)
        (entry_vld != entry_vld_par) |-> tag_bad);

    // R2
    gate_chk: assert property (@(posedge clk) disable iff (rst)
        !entry_vld |-> !(tag_res.lo_rng_err || tag_res.hi_rng_err));
endmodule

// File: tb/icache_parity_chk_bench.sv
`timescale 1ns/1ps
module icache_parity_chk_bench;
    localparam int NB = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic          tag_valid = 0, tag_ready, entry_vld = 0, entry_vld_par = 0, tag_has_data = 0;
    logic [63:0]   tag_lo = '0;
    logic          beat_valid = 0, beat_ready;
    logic [31:0]   beat_insn_a = '0, beat_insn_b = '0;
    logic [16:0]   beat_side = '0;
    logic          done, tag_err, data_err;
    logic [NB-1:0] fail_mask;

    icache_parity_chk #(.NUM_BEATS(NB)) u_icache_parity_chk (
        .clk(clk), .rst(rst), .tag_valid(tag_valid), .tag_ready(tag_ready),
        .tag_lo(tag_lo), .entry_vld(entry_vld), .entry_vld_par(entry_vld_par),
        .tag_has_data(tag_has_data), .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_insn_a(beat_insn_a), .beat_insn_b(beat_insn_b), .beat_side(beat_side),
        .done(done), .tag_err(tag_err), .data_err(data_err), .fail_mask(fail_mask)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [31:0] rng = 32'h1234_5679;
    logic [31:0] ba [NB];
    logic [31:0] bb [NB];
    logic [16:0] bs [NB];

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    function automatic logic [31:0] nxt();
        rng ^= rng << 13;
        rng ^= rng >> 17;
        rng ^= rng << 5;
        return rng;
    endfunction

    function automatic logic odd(input logic [63:0] x);
        return logic'($countones(x) % 2);
    endfunction

    // R5: bit 3 from byte 31:24 down to bit 0 from byte 7:0
    function automatic logic [3:0] code_of(input logic [31:0] w);
        logic [3:0] c;
        c[3] = odd({32'h0, w[31:24]});
        c[2] = odd({32'h0, w[23:16]});
        c[1] = odd({32'h0, w[15:8]});
        c[0] = odd({32'h0, w[7:0]});
        return c;
    endfunction

    function automatic logic exp_tag(input logic [63:0] lo, input logic v, input logic vp);
        logic [63:0] low;
        logic bad;
        low = lo & 64'h0000_0000_00FF_F3FF;
        bad = (v != vp);
        if (v) begin
            if (lo[10] != odd(low)) bad = 1;
            if (lo[11] != odd(lo >> 24)) bad = 1;
        end
        return bad;
    endfunction

    function automatic logic exp_beat(input logic [31:0] a, input logic [31:0] b, input logic [16:0] s);
        return (s[16] != odd({56'h0, s[15:8]})) || (s[7:4] != code_of(a)) || (s[3:0] != code_of(b));
    endfunction

    function automatic logic [63:0] good_lo(input logic [63:0] lo);
        logic [63:0] r;
        r = lo;
        r[10] = odd(r & 64'h0000_0000_00FF_F3FF);
        r[11] = odd(r >> 24);
        return r;
    endfunction

    function automatic logic [16:0] good_side(input logic [31:0] a, input logic [31:0] b, input logic [7:0] pd);
        return {odd({56'h0, pd}), pd, code_of(a), code_of(b)};
    endfunction

    task automatic run_entry(input logic [63:0] lo, input logic v, input logic vp,
                             input logic hd, input logic [31:0] gaps, input string tagname);
        logic et, ed;
        logic [NB-1:0] em;
        @(negedge clk);
        while (!tag_ready) @(negedge clk);
        tag_lo = lo; entry_vld = v; entry_vld_par = vp; tag_has_data = hd; tag_valid = 1;
        @(posedge clk);
        @(negedge clk);
        tag_valid = 0;
        et = exp_tag(lo, v, vp);
        ed = 0;
        em = '0;
        if (hd) begin
            // R8: waiting for beats, no tag taken, no completion yet
            chk("R8 done low while beats pending", {63'h0, done}, 64'h0);
            chk("R8 tag_ready low in beat phase", {63'h0, tag_ready}, 64'h0);
            for (int i = 0; i < NB; i++) begin
                for (int g = 0; g < int'((gaps >> (2 * i)) & 3); g++) @(negedge clk);
                beat_insn_a = ba[i]; beat_insn_b = bb[i]; beat_side = bs[i]; beat_valid = 1;
                @(posedge clk);
                @(negedge clk);
                beat_valid = 0;
                em[i] = exp_beat(ba[i], bb[i], bs[i]);
            end
            ed = |em;
        end
        chk({"R8 done pulse ", tagname}, {63'h0, done}, 64'h1);
        chk({"R1/R2/R3 tag_err ", tagname}, {63'h0, tag_err}, {63'h0, et});
        chk({"R4/R5/R7 data_err ", tagname}, {63'h0, data_err}, {63'h0, ed});
        chk({"R6 fail_mask ", tagname}, {60'h0, fail_mask}, {60'h0, em});
        @(negedge clk);
        chk("R8 done one cycle", {63'h0, done}, 64'h0);
        chk("R7 results hold after done", {62'h0, tag_err, data_err}, {62'h0, et, ed});
    endtask

    task automatic fill_beats(input bit corrupt);
        for (int i = 0; i < NB; i++) begin
            logic [31:0] r;
            ba[i] = nxt(); bb[i] = nxt(); r = nxt();
            bs[i] = good_side(ba[i], bb[i], r[7:0]);
            if (corrupt && r[10:8] < 3) begin
                case (r[12:11])
                    2'd0: bs[i] = bs[i] ^ (17'h1 << (r[20:16] % 17));
                    2'd1: ba[i] = ba[i] ^ (32'h1 << r[25:21]);
                    default: bb[i] = bb[i] ^ (32'h1 << r[30:26]);
                endcase
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R9 reset state
        chk("R9 tag_ready after reset", {63'h0, tag_ready}, 64'h1);
        chk("R9 beat_ready after reset", {63'h0, beat_ready}, 64'h0);
        chk("R9 done after reset", {63'h0, done}, 64'h0);
        chk("R9 flags after reset", {59'h0, tag_err, data_err, fail_mask}, 64'h0);

        // R8: a beat offered while idle is ignored
        beat_valid = 1; beat_side = 17'h1_0000;
        @(posedge clk); @(negedge clk);
        beat_valid = 0;
        chk("R8 beat ignored while idle", {59'h0, done, data_err, fail_mask}, 64'h0);

        // R1: bit 10 wrong with valid set
        run_entry(good_lo(64'h0123_4567_89AB_CDEF) ^ 64'h400, 1, 1, 0, 0, "R1 bit10");
        // R2: bit 11 wrong with valid set
        run_entry(good_lo(64'hFEDC_BA98_7654_3210) ^ 64'h800, 1, 1, 0, 0, "R2 bit11");
        // R2: both ranges wrong but entry invalid -> no effect
        run_entry(good_lo(64'h5555_AAAA_0F0F_F0F0) ^ 64'hC00, 0, 0, 0, 0, "R2 gated");
        // R3: copy mismatch on an invalid entry
        run_entry(good_lo(64'h0), 0, 1, 0, 0, "R3 mismatch");

        // R4: every beat with bad predecode parity
        fill_beats(0);
        for (int i = 0; i < NB; i++) bs[i][16] = ~bs[i][16];
        run_entry(good_lo(64'h77), 1, 1, 1, 32'h1B, "R4 predecode");
        // R7: a following entry without data clears stale results
        run_entry(good_lo(64'h99), 1, 1, 0, 0, "R7 clear");
        // R5 / R6: only beat 2 bad in instruction A, top byte
        fill_beats(0);
        ba[2] = ba[2] ^ 32'h0100_0000;
        run_entry(good_lo(64'h1), 1, 1, 1, 0, "R5 beat2");

        for (int n = 0; n < 400; n++) begin
            logic [31:0] r, h, l, gp;
            logic [63:0] lo;
            r = nxt(); h = nxt(); l = nxt(); gp = nxt();
            lo = good_lo({h, l});
            if (r[0]) lo = lo ^ (64'h1 << r[6:1]);
            fill_beats(1);
            run_entry(lo, r[7], (r[9:8] == 0) ? ~r[7] : r[7], r[11:10] != 0, gp, "R6 random");
        end
        finish_run();
    end
endmodule